// File: doc/BRIEF.md
# Multiplexed-Bus Byte Memory Slave

This block connects a small byte-wide memory to a host that uses a multiplexed address/data bus, as 8-bit microcontrollers do. The host's pins are asynchronous to the fast system clock. The block samples them through a two-stage synchronizer and works only on the sampled copies. When the address strobe falls, the block stores a 13-bit address made of the low multiplexed byte and five dedicated high pins. At the same moment it decides, from the chip-enable level, whether this cycle selects the device.

Two independent active-low read strobes, a data read and a code fetch, place the addressed byte on the shared bus. The block returns an output-enable that the host-side pad logic uses. A write strobe captures the bus byte on its rising edge. The write then waits out a short hold window. During that window a rising write-lock input cancels it. After the window the byte is committed and the store reports busy for a fixed time. The backing store is a behavioural byte array of 2^MEM_AW entries, indexed by the low address bits.

Top module: `mbs_slave`

## Requirements
- R1: On the falling edge of the sampled `ale_i`, the address {`addr_hi_i`, `ad_i`} (13 bits, `addr_hi_i` as bits 12..8) is stored. The store uses only its low MEM_AW bits, so with MEM_AW=10 the addresses 0x6C4 and 0x2C4 reach the same byte.
- R2: The device is selected for a cycle only if `ce_n_i` was already low when `ale_i` fell. A `ce_n_i` that drops after the fall leaves the cycle unselected, and no read or write occurs.
- R3: While `ce_n_i` is high and `ale_i` is low, `ad_oe_o` stays 0, `ad_o` stays 0 and no write is accepted.
- R4: With the device selected, `rd_n_i` low and both `code_rd_n_i` and `wr_n_i` high, `ad_oe_o` is 1 and `ad_o` carries the byte at the stored address.
- R5: With the device selected, `code_rd_n_i` low and both `rd_n_i` and `wr_n_i` high, the addressed byte is driven in the same way as in R4.
- R6: `ad_oe_o` returns to 0 no later than three clocks after the read strobe pin rises: two synchronizer stages plus one output register.
- R7: A write is taken only when `wr_n_i` is low, `rd_n_i` is high and `wlock_i` is low. The byte on `ad_i` just before `wr_n_i` rises is the one stored. Holding `wlock_i` high blocks every write.
- R8: A captured write waits HOLD_CYC clocks before it commits. If `wlock_i` is high during that wait, the write is dropped and `busy_o` never rises for it. A rise of `wlock_i` after the commit has no effect on the stored byte.
- R9: On commit, `busy_o` is 1 for BUSY_CYC clocks. Writes begun while a write is held or busy are ignored. Reads during busy return the committed byte.
- R10: If `wr_n_i` is low together with `rd_n_i` or `code_rd_n_i`, the block does nothing: `ad_oe_o` stays 0 and no byte is written.
- R11: After reset, `ad_oe_o`, `ad_o` and `busy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the host strobes |
| rst | input | 1 | Synchronous active-high reset |
| ale_i | input | 1 | Address strobe; its fall stores the address and the select |
| ce_n_i | input | 1 | Active-low chip enable |
| addr_hi_i | input | 5 | Address bits 12..8 |
| ad_i | input | 8 | Multiplexed bus as seen by the pads: low address byte, then write data |
| ad_o | output | 8 | Read data for the multiplexed bus |
| ad_oe_o | output | 1 | Pad output enable for `ad_o` |
| rd_n_i | input | 1 | Active-low data read strobe |
| code_rd_n_i | input | 1 | Active-low code-fetch read strobe |
| wr_n_i | input | 1 | Active-low write strobe; its rise captures the data |
| wlock_i | input | 1 | High blocks writes and cancels a held write |
| busy_o | output | 1 | Store is completing a committed write |

## Verification
Some internal faults show up at the pins within three clocks. A wrong select or decode state drives `ad_oe_o` during a standby, late-enable or conflicting-strobe cycle, or leaves it low during a valid read. A bad address latch returns the byte of another location on the next read.

Other faults appear later. A hold-window or busy counter that is off, or a cancel path that is broken, only shows after the commit would have happened: `busy_o` has the wrong level about twenty clocks after the strobe, or a later read returns a byte that should have been dropped or kept.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    localparam int AD_W   = 8;
    localparam int HI_W   = 5;
    localparam int ADDR_W = AD_W + HI_W;

    // Sampled copy of every host pin, moved through the synchronizer as one word.
    typedef struct packed {
        logic            ale;
        logic            ce_n;
        logic            rd_n;
        logic            code_n;
        logic            wr_n;
        logic            wlock;
        logic [HI_W-1:0] hi;
        logic [AD_W-1:0] ad;
    } pins_t;

    localparam int PINS_W = $bits(pins_t);

    localparam pins_t PINS_IDLE = '{ale: 1'b0, ce_n: 1'b1, rd_n: 1'b1, code_n: 1'b1,
                                    wr_n: 1'b1, wlock: 1'b1, hi: '0, ad: '0};

    typedef enum logic [1:0] {OP_NONE, OP_DATA_RD, OP_CODE_RD, OP_WRITE} op_e;

    typedef enum logic [1:0] {WS_IDLE, WS_HOLD, WS_BUSY} wstate_e;

    // Only a single clean strobe counts; every other combination is a no-op.
    function automatic op_e classify(input pins_t p, input logic active);
        op_e r;
        r = OP_NONE;
        if (active) begin
            case ({p.rd_n, p.code_n, p.wr_n})
                3'b011:  r = OP_DATA_RD;
                3'b101:  r = OP_CODE_RD;
                3'b110:  r = OP_WRITE;
                default: r = OP_NONE;
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/mbs_frontend.sv
module mbs_frontend
    import mbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pins_t             pins,
    input  logic              can_accept,
    output logic [ADDR_W-1:0] addr,
    output op_e               op,
    output logic              sel_active,
    output logic              wr_pulse,
    output logic [AD_W-1:0]   wr_data
);
    pins_t prev;
    logic  sel_q;
    logic  armed_q;
    logic  ale_fall;

    assign ale_fall   = prev.ale & ~pins.ale;
    assign sel_active = sel_q & ~pins.ce_n & ~pins.ale;
    assign op         = classify(pins, sel_active);
    assign wr_pulse   = armed_q & pins.wr_n & ~prev.wr_n;
    assign wr_data    = prev.ad;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev    <= PINS_IDLE;
            sel_q   <= 1'b0;
            armed_q <= 1'b0;
            addr    <= '0;
        end else begin
            prev <= pins;
            if (ale_fall) begin
                addr  <= {pins.hi, pins.ad};
                sel_q <= ~pins.ce_n;
            end
            // Arm only if the store was free when the strobe began; stay armed while it is clean.
            armed_q <= (op == OP_WRITE) && !pins.wlock && (armed_q || can_accept);
        end
    end
endmodule

// File: rtl/mbs_store.sv
module mbs_store
    import mbs_pkg::*;
#(
    parameter int MEM_AW   = 10,
    parameter int HOLD_CYC = 13,
    parameter int BUSY_CYC = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [AD_W-1:0]   rd_data,
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [AD_W-1:0]   wr_data,
    input  logic              wlock,
    output logic              can_accept,
    output logic              pending,
    output logic              busy,
    output logic              commit
);
    localparam int DEPTH   = 1 << MEM_AW;
    localparam int CNT_MAX = (HOLD_CYC > BUSY_CYC) ? HOLD_CYC : BUSY_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [AD_W-1:0]   mem [DEPTH];
    wstate_e           st;
    logic [CNT_W-1:0]  cnt;
    logic [MEM_AW-1:0] p_addr;
    logic [AD_W-1:0]   p_data;

    assign can_accept = (st == WS_IDLE);
    assign pending    = (st == WS_HOLD);
    assign busy       = (st == WS_BUSY);
    assign commit     = (st == WS_HOLD) && !wlock && (cnt == '0);
    assign rd_data    = mem[rd_addr[MEM_AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= WS_IDLE;
            cnt    <= '0;
            p_addr <= '0;
            p_data <= '0;
        end else begin
            case (st)
                WS_IDLE: begin
                    if (wr_pulse) begin
                        st     <= WS_HOLD;
                        cnt    <= CNT_W'(HOLD_CYC - 1);
                        p_addr <= wr_addr[MEM_AW-1:0];
                        p_data <= wr_data;
                    end
                end
                WS_HOLD: begin
                    if (wlock) begin
                        st <= WS_IDLE;
                    end else if (cnt == '0) begin
                        st  <= WS_BUSY;
                        cnt <= CNT_W'(BUSY_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                WS_BUSY: begin
                    if (cnt == '0) st <= WS_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: st <= WS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (commit) mem[p_addr] <= p_data;
    end
endmodule

// File: rtl/mbs_slave.sv
module mbs_slave
    import mbs_pkg::*;
#(
    parameter int MEM_AW   = 10,
    parameter int HOLD_CYC = 13,
    parameter int BUSY_CYC = 40
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ale_i,
    input  logic            ce_n_i,
    input  logic [HI_W-1:0] addr_hi_i,
    input  logic [AD_W-1:0] ad_i,
    output logic [AD_W-1:0] ad_o,
    output logic            ad_oe_o,
    input  logic            rd_n_i,
    input  logic            code_rd_n_i,
    input  logic            wr_n_i,
    input  logic            wlock_i,
    output logic            busy_o
);
    pins_t             raw;
    logic [PINS_W-1:0] sync_q;
    pins_t             pins;
    logic [ADDR_W-1:0] addr;
    op_e               op;
    logic              sel_active;
    logic              wr_pulse;
    logic [AD_W-1:0]   wr_data;
    logic [AD_W-1:0]   rd_data;
    logic              can_accept;
    logic              pending;
    logic              busy;
    logic              commit;
    logic              rd_go;

    assign raw = '{ale: ale_i, ce_n: ce_n_i, rd_n: rd_n_i, code_n: code_rd_n_i,
                   wr_n: wr_n_i, wlock: wlock_i, hi: addr_hi_i, ad: ad_i};

    mbs_sync #(.W(PINS_W), .RST_VAL(PINS_IDLE)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(sync_q)
    );
    assign pins = pins_t'(sync_q);

    mbs_frontend u_front (
        .clk(clk), .rst(rst), .pins(pins), .can_accept(can_accept),
        .addr(addr), .op(op), .sel_active(sel_active),
        .wr_pulse(wr_pulse), .wr_data(wr_data)
    );

    mbs_store #(.MEM_AW(MEM_AW), .HOLD_CYC(HOLD_CYC), .BUSY_CYC(BUSY_CYC)) u_store (
        .clk(clk), .rst(rst), .rd_addr(addr), .rd_data(rd_data),
        .wr_pulse(wr_pulse), .wr_addr(addr), .wr_data(wr_data), .wlock(pins.wlock),
        .can_accept(can_accept), .pending(pending), .busy(busy), .commit(commit)
    );

    assign rd_go  = (op == OP_DATA_RD) || (op == OP_CODE_RD);
    assign busy_o = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ad_oe_o <= 1'b0;
            ad_o    <= '0;
        end else begin
            ad_oe_o <= rd_go;
            ad_o    <= rd_go ? rd_data : '0;
        end
    end
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker (
    input logic clk,
    input logic rst,
    input logic ad_oe,
    input logic standby,
    input logic conflict,
    input logic pending,
    input logic busy,
    input logic wlock
);
    assert_standby_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        standby |=> !ad_oe);

    assert_conflict_nop_R10: assert property (@(posedge clk) disable iff (rst)
        conflict |=> !ad_oe);

    assert_hold_needs_unlock_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> !$past(wlock, 2));

    assert_cancel_drops_R8: assert property (@(posedge clk) disable iff (rst)
        (pending && wlock) |=> (!pending && !busy));

    assert_no_hold_from_busy_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> !$past(busy));

    assert_busy_after_hold_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(pending));
endmodule

bind mbs_slave mbs_checker u_chk (
    .clk(clk),
    .rst(rst),
    .ad_oe(ad_oe_o),
    .standby(pins.ce_n & ~pins.ale),
    .conflict(~pins.wr_n & (~pins.rd_n | ~pins.code_n)),
    .pending(pending),
    .busy(busy),
    .wlock(pins.wlock)
);

// File: tb/test_mbs_slave.sv
module test_mbs_slave;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ale = 1'b0;
    logic       ce_n = 1'b1;
    logic [4:0] addr_hi = '0;
    logic [7:0] ad_i = '0;
    logic [7:0] ad_o;
    logic       ad_oe;
    logic       rd_n = 1'b1;
    logic       code_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       wlock = 1'b0;
    logic       busy;

    int nchk = 0;
    int nfail = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mbs_slave i_mbs_slave (
        .clk(clk), .rst(rst), .ale_i(ale), .ce_n_i(ce_n), .addr_hi_i(addr_hi),
        .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe), .rd_n_i(rd_n),
        .code_rd_n_i(code_n), .wr_n_i(wr_n), .wlock_i(wlock), .busy_o(busy)
    );

    // {op, addr, data}: op 0 = write, 1 = data read, 2 = code-fetch read
    localparam logic [22:0] VEC [13] = '{
        {2'd0, 13'h0005, 8'hA5},
        {2'd0, 13'h01F3, 8'h5C},
        {2'd0, 13'h03FF, 8'h3C},
        {2'd0, 13'h02C4, 8'h77},
        {2'd1, 13'h0005, 8'hA5},
        {2'd2, 13'h01F3, 8'h5C},
        {2'd1, 13'h03FF, 8'h3C},
        {2'd2, 13'h02C4, 8'h77},
        {2'd1, 13'h06C4, 8'h77},
        {2'd0, 13'h0005, 8'h11},
        {2'd2, 13'h0005, 8'h11},
        {2'd1, 13'h01F3, 8'h5C},
        {2'd2, 13'h03FF, 8'h3C}
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    task automatic latch(input logic [12:0] a, input logic ce_early);
        ale = 1'b1; ad_i = a[7:0]; addr_hi = a[12:8]; ce_n = !ce_early;
        cyc(4);
        ale = 1'b0;
        cyc(4);
        ce_n = 1'b0; ad_i = '0;
        cyc(2);
    endtask

    task automatic do_read(input logic psen, output logic [7:0] d, output logic oe);
        if (psen) code_n = 1'b0; else rd_n = 1'b0;
        cyc(6);
        d = ad_o; oe = ad_oe;
        rd_n = 1'b1; code_n = 1'b1;
        cyc(4);
    endtask

    task automatic do_write(input logic [7:0] d);
        ad_i = d; wr_n = 1'b0;
        cyc(5);
        wr_n = 1'b1;
        cyc(4);
        ad_i = '0;
    endtask

    task automatic read_at(input logic [12:0] a, input logic psen, output logic [7:0] d);
        logic oe;
        latch(a, 1'b1);
        do_read(psen, d, oe);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            nfail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            summary();
        end
    end

    initial begin
        logic [7:0] d;
        logic       oe;
        cyc(5);
        rst = 1'b0;
        cyc(2);
        // R11: reset state
        check("R11 oe", ad_oe, 0);
        check("R11 data", ad_o, 0);
        check("R11 busy", busy, 0);

        for (int i = 0; i < 13; i++) begin
            logic [22:0] v;
            v = VEC[i];
            latch(v[20:8], 1'b1);
            if (v[22:21] == 2'd0) begin
                do_write(v[7:0]);
                cyc(70);
            end else begin
                do_read(v[22:21] == 2'd2, d, oe);
                check("R4/R5 read oe", oe, 1);
                check("R4/R5/R1 read data", d, v[7:0]);
            end
        end

        // R2: enable arriving after the strobe fell does not select
        latch(13'h0005, 1'b0);
        do_read(1'b0, d, oe);
        check("R2 late enable oe", oe, 0);

        // R3: standby, no drive and no write
        latch(13'h0005, 1'b1);
        ce_n = 1'b1;
        cyc(2);
        do_read(1'b0, d, oe);
        check("R3 standby oe", oe, 0);
        check("R3 standby data", d, 0);
        do_write(8'hEE);
        cyc(70);
        read_at(13'h0005, 1'b0, d);
        check("R3 standby write ignored", d, 8'h11);

        // R6: output enable release timing
        latch(13'h0005, 1'b1);
        rd_n = 1'b0;
        cyc(6);
        check("R6 oe while active", ad_oe, 1);
        rd_n = 1'b1;
        cyc(3);
        check("R6 oe released", ad_oe, 0);
        cyc(2);

        // R7: lock held high blocks the write
        wlock = 1'b1;
        latch(13'h0005, 1'b1);
        do_write(8'h22);
        cyc(70);
        wlock = 1'b0;
        read_at(13'h0005, 1'b1, d);
        check("R7 locked write ignored", d, 8'h11);

        // R8: lock rising inside the hold window cancels
        latch(13'h03FF, 1'b1);
        do_write(8'h99);
        wlock = 1'b1;
        cyc(20);
        check("R8 no busy after cancel", busy, 0);
        wlock = 1'b0;
        cyc(60);
        read_at(13'h03FF, 1'b0, d);
        check("R8 cancelled write", d, 8'h3C);

        // R8: lock rising after commit is harmless
        latch(13'h03FF, 1'b1);
        do_write(8'h99);
        cyc(40);
        wlock = 1'b1;
        cyc(5);
        wlock = 1'b0;
        cyc(40);
        read_at(13'h03FF, 1'b0, d);
        check("R8 late lock keeps data", d, 8'h99);

        // R9: busy, ignored write and reads while busy
        latch(13'h01F3, 1'b1);
        do_write(8'hE1);
        cyc(16);
        check("R9 busy after commit", busy, 1);
        latch(13'h01F3, 1'b1);
        do_write(8'hF0);
        read_at(13'h01F3, 1'b1, d);
        check("R9 read during busy", d, 8'hE1);
        cyc(80);
        check("R9 busy ends", busy, 0);
        read_at(13'h01F3, 1'b0, d);
        check("R9 write during busy ignored", d, 8'hE1);

        // R10: conflicting strobes
        latch(13'h0005, 1'b1);
        ad_i = 8'h55; rd_n = 1'b0; wr_n = 1'b0;
        cyc(6);
        check("R10 rd+wr oe", ad_oe, 0);
        rd_n = 1'b1; wr_n = 1'b1;
        cyc(4);
        code_n = 1'b0; wr_n = 1'b0;
        cyc(6);
        check("R10 code+wr oe", ad_oe, 0);
        code_n = 1'b1; wr_n = 1'b1;
        cyc(4);
        ad_i = '0;
        cyc(70);
        read_at(13'h0005, 1'b0, d);
        check("R10 no write stored", d, 8'h11);

        summary();
    end
endmodule